// File: doc/BRIEF.md
# Descriptor Ring Queue Register File with Tail Doorbell

This block holds the control registers of a multi-queue DMA engine that walks descriptor rings in memory. Every queue has its own register window on a 32-bit register bus. In that window software programs a 64-bit ring base address, given as two 32-bit words, and a ring size counted in descriptors. It reads a head pointer that the engine moves forward. It reads a tail pointer that it can never write directly. To hand descriptors to the engine, software writes a count to a separate doorbell register, and the tail moves forward by that count, wrapping at the ring size.

A software-control register brings the tail back to zero so that a ring can be armed again. On a transmit build, a second write-only increment register can be enabled. It drives an independent data tail that the engine sees.

The engine side of the block works per queue. It gets the base, size, head and tail as plain vectors. It gets a pending flag that is high while unconsumed descriptors remain, and a one-cycle kick pulse for each doorbell that is accepted. It sends back a consume strobe that moves the head forward by one descriptor. Descriptor fetch and the data path sit outside this block.

Top module: `dmaq_ring_csr`

## Requirements
- R1: The window of queue q starts at byte address (q+1)*0x1000. Inside it, 0x28 holds the low base word, 0x2C the high base word and 0x30 the ring size. All three read back what was written, and the base appears on `eng_base` as {high, low}.
- R2: Writing N to offset 0x38 with N smaller than the ring size moves the tail to (tail + N) mod size, in the cycle of the write. `eng_kick` for that queue pulses for exactly that one cycle.
- R3: A doorbell write is ignored, with no tail change and no kick, when the ring size is zero or when N is equal to or larger than the ring size.
- R4: Offset 0x3C reads the tail. Writes to 0x3C and to the head at 0x34 change nothing.
- R5: A one-cycle `eng_consume` strobe moves the head forward by one and wraps to zero at the ring size. The strobe is ignored while the head equals the tail.
- R6: `eng_pending` for a queue is 1 exactly while its tail differs from its head.
- R7: Writing a value with bit 0 set to the software-control offset clears the tail and the data tail. This offset is 0xB0 when IS_TX=1 and 0x64 when IS_TX=0. The offset of the other direction is unmapped.
- R8: When IS_TX=1 and HAS_DATA_TAIL=1, writing N to 0xE0 moves the data tail by N under the same rules as R2 and R3. In every other build, 0xE0 is unmapped and the data tail stays at zero.
- R9: Every access sets `bus_ack` in the next cycle. A read shows its data on `bus_rdata` in that same cycle. Reads return zero for the doorbell, the data-tail increment, the software control, any unmapped offset, and any window beyond the last queue.
- R10: A doorbell write and a consume strobe on the same queue in the same cycle both take effect.
- R11: After reset, all pointers, sizes, base words, pending flags, kicks, `bus_ack` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access completed, one cycle after request |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| eng_consume | input | NUM_Q | Per-queue head-advance strobe |
| eng_pending | output | NUM_Q | Per-queue tail differs from head |
| eng_kick | output | NUM_Q | Per-queue accepted-doorbell pulse |
| eng_base | output | NUM_Q*64 | Per-queue ring base address |
| eng_len | output | NUM_Q*PTR_W | Per-queue ring size |
| eng_head | output | NUM_Q*PTR_W | Per-queue head pointer |
| eng_tail | output | NUM_Q*PTR_W | Per-queue tail pointer |
| eng_data_tail | output | NUM_Q*PTR_W | Per-queue independent data tail |

## Verification
The bench builds two copies of the block with three queues and 8-bit pointers, and drives both from one bus. One copy is a transmit build with the data tail enabled. The other is a receive build with the same option set. Because both see the same writes, one run shows both software-control offsets and shows the data-tail increment being gated off in the receive build. Three queues make it possible to check the unmapped window above the last queue, and to check that writes to one queue leave the others alone. A small ring of eight descriptors makes doorbell wrap, head wrap and over-size doorbells reachable within a few accesses.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

  // Register selected by the low 12 address bits of a queue window.
  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_BASE_LO,
    SEL_BASE_HI,
    SEL_LEN,
    SEL_HEAD,
    SEL_DBELL,
    SEL_TAIL,
    SEL_SWCTRL,
    SEL_DTAIL
  } dmaq_sel_e;

  localparam logic [11:0] OFF_BASE_LO   = 12'h028;
  localparam logic [11:0] OFF_BASE_HI   = 12'h02C;
  localparam logic [11:0] OFF_LEN       = 12'h030;
  localparam logic [11:0] OFF_HEAD      = 12'h034;
  localparam logic [11:0] OFF_DBELL     = 12'h038;
  localparam logic [11:0] OFF_TAIL      = 12'h03C;
  localparam logic [11:0] OFF_SWCTRL_RX = 12'h064;
  localparam logic [11:0] OFF_SWCTRL_TX = 12'h0B0;
  localparam logic [11:0] OFF_DTAIL     = 12'h0E0;

  localparam int WIN_SHIFT = 12;

  // Decode one in-window offset for a given build variant.
  function automatic dmaq_sel_e dmaq_decode(input logic [11:0] off,
                                            input bit is_tx,
                                            input bit has_dt);
    dmaq_sel_e s;
    s = SEL_NONE;
    case (off)
      OFF_BASE_LO:   s = SEL_BASE_LO;
      OFF_BASE_HI:   s = SEL_BASE_HI;
      OFF_LEN:       s = SEL_LEN;
      OFF_HEAD:      s = SEL_HEAD;
      OFF_DBELL:     s = SEL_DBELL;
      OFF_TAIL:      s = SEL_TAIL;
      OFF_SWCTRL_TX: s = is_tx ? SEL_SWCTRL : SEL_NONE;
      OFF_SWCTRL_RX: s = is_tx ? SEL_NONE : SEL_SWCTRL;
      OFF_DTAIL:     s = (is_tx && has_dt) ? SEL_DTAIL : SEL_NONE;
      default:       s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dmaq_addr_dec.sv
module dmaq_addr_dec
  import dmaq_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int NUM_Q         = 4,
  parameter bit IS_TX         = 1'b1,
  parameter bit HAS_DATA_TAIL = 1'b1,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [QW-1:0]     q_idx,
  output dmaq_sel_e         sel
);

  localparam int WW = ADDR_W - WIN_SHIFT;

  logic [WW-1:0] win;
  logic          win_ok;

  assign win    = addr[ADDR_W-1:WIN_SHIFT];
  // Window 0 is below the first queue; windows above NUM_Q are unmapped.
  assign win_ok = (win != '0) && (int'(win) <= NUM_Q);
  assign q_idx  = QW'(win - WW'(1));

  always_comb begin
    sel = dmaq_decode(addr[WIN_SHIFT-1:0], IS_TX, HAS_DATA_TAIL);
    if (!win_ok) sel = SEL_NONE;
  end

  assign hit = (sel != SEL_NONE);

endmodule

// File: rtl/dmaq_queue.sv
module dmaq_queue
  import dmaq_pkg::*;
#(
  parameter int PTR_W         = 16,
  parameter bit IS_TX         = 1'b1,
  parameter bit HAS_DATA_TAIL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  dmaq_sel_e        sel,
  input  logic [31:0]      wdata,
  input  logic             consume,
  output logic [31:0]      base_lo,
  output logic [31:0]      base_hi,
  output logic [PTR_W-1:0] len,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [PTR_W-1:0] dtail,
  output logic             pending,
  output logic             kick
);

  // Add a count below the ring size and wrap with one subtraction.
  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                input logic [PTR_W-1:0] n,
                                                input logic [PTR_W-1:0] size);
    logic [PTR_W:0] s;
    s = {1'b0, p} + {1'b0, n};
    if (s >= {1'b0, size}) s = s - {1'b0, size};
    return s[PTR_W-1:0];
  endfunction

  logic             len_nz;
  logic             cnt_ok;
  logic             db_ok;
  logic             swrst;
  logic             adv_ok;
  logic [PTR_W-1:0] tail_nxt;
  logic [PTR_W-1:0] head_nxt;

  assign len_nz = (len != '0);
  assign cnt_ok = len_nz && (wdata < 32'(len));
  assign db_ok  = we && (sel == SEL_DBELL) && cnt_ok;
  assign swrst  = we && (sel == SEL_SWCTRL) && wdata[0];
  assign adv_ok = consume && len_nz && (head != tail);

  always_comb begin
    tail_nxt = tail;
    if (swrst)      tail_nxt = '0;
    else if (db_ok) tail_nxt = wrap_add(tail, wdata[PTR_W-1:0], len);
  end

  always_comb begin
    head_nxt = head;
    if (adv_ok) head_nxt = wrap_add(head, PTR_W'(1), len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo <= '0;
      base_hi <= '0;
      len     <= '0;
      head    <= '0;
      tail    <= '0;
      pending <= 1'b0;
      kick    <= 1'b0;
    end else begin
      if (we && sel == SEL_BASE_LO) base_lo <= wdata;
      if (we && sel == SEL_BASE_HI) base_hi <= wdata;
      if (we && sel == SEL_LEN)     len     <= wdata[PTR_W-1:0];
      head    <= head_nxt;
      tail    <= tail_nxt;
      pending <= (tail_nxt != head_nxt);
      kick    <= db_ok;
    end
  end

  generate
    if (IS_TX && HAS_DATA_TAIL) begin : g_dtail
      logic dt_ok;
      assign dt_ok = we && (sel == SEL_DTAIL) && cnt_ok;
      always_ff @(posedge clk) begin
        if (rst)        dtail <= '0;
        else if (swrst) dtail <= '0;
        else if (dt_ok) dtail <= wrap_add(dtail, wdata[PTR_W-1:0], len);
      end
    end else begin : g_no_dtail
      assign dtail = '0;
    end
  endgenerate

endmodule

// File: rtl/dmaq_rd_mux.sv
module dmaq_rd_mux
  import dmaq_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int PTR_W = 16,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                        hit,
  input  logic [QW-1:0]               q_idx,
  input  dmaq_sel_e                   sel,
  input  logic [NUM_Q-1:0][31:0]      base_lo,
  input  logic [NUM_Q-1:0][31:0]      base_hi,
  input  logic [NUM_Q-1:0][PTR_W-1:0] len,
  input  logic [NUM_Q-1:0][PTR_W-1:0] head,
  input  logic [NUM_Q-1:0][PTR_W-1:0] tail,
  output logic [31:0]                 rdata
);

  always_comb begin
    rdata = '0;
    if (hit && int'(q_idx) < NUM_Q) begin
      case (sel)
        SEL_BASE_LO: rdata = base_lo[q_idx];
        SEL_BASE_HI: rdata = base_hi[q_idx];
        SEL_LEN:     rdata = 32'(len[q_idx]);
        SEL_HEAD:    rdata = 32'(head[q_idx]);
        SEL_TAIL:    rdata = 32'(tail[q_idx]);
        default:     rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dmaq_ring_csr.sv
module dmaq_ring_csr
  import dmaq_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int NUM_Q         = 4,
  parameter int PTR_W         = 16,
  parameter bit IS_TX         = 1'b1,
  parameter bit HAS_DATA_TAIL = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic                   bus_ack,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_Q-1:0]       eng_consume,
  output logic [NUM_Q-1:0]       eng_pending,
  output logic [NUM_Q-1:0]       eng_kick,
  output logic [NUM_Q*64-1:0]    eng_base,
  output logic [NUM_Q*PTR_W-1:0] eng_len,
  output logic [NUM_Q*PTR_W-1:0] eng_head,
  output logic [NUM_Q*PTR_W-1:0] eng_tail,
  output logic [NUM_Q*PTR_W-1:0] eng_data_tail
);

  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic                        hit;
  logic [QW-1:0]               q_idx;
  dmaq_sel_e                   sel;
  logic [31:0]                 rd_mux;
  logic [NUM_Q-1:0][31:0]      base_lo;
  logic [NUM_Q-1:0][31:0]      base_hi;
  logic [NUM_Q-1:0][PTR_W-1:0] len;
  logic [NUM_Q-1:0][PTR_W-1:0] head;
  logic [NUM_Q-1:0][PTR_W-1:0] tail;
  logic [NUM_Q-1:0][PTR_W-1:0] dtail;

  dmaq_addr_dec #(
    .ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .IS_TX(IS_TX), .HAS_DATA_TAIL(HAS_DATA_TAIL)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .q_idx(q_idx), .sel(sel)
  );

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic we_q;
      assign we_q = bus_valid && bus_write && hit && (int'(q_idx) == q);

      dmaq_queue #(
        .PTR_W(PTR_W), .IS_TX(IS_TX), .HAS_DATA_TAIL(HAS_DATA_TAIL)
      ) u_queue (
        .clk(clk), .rst(rst), .we(we_q), .sel(sel), .wdata(bus_wdata),
        .consume(eng_consume[q]),
        .base_lo(base_lo[q]), .base_hi(base_hi[q]), .len(len[q]),
        .head(head[q]), .tail(tail[q]), .dtail(dtail[q]),
        .pending(eng_pending[q]), .kick(eng_kick[q])
      );

      assign eng_base[q*64 +: 64]         = {base_hi[q], base_lo[q]};
      assign eng_len[q*PTR_W +: PTR_W]       = len[q];
      assign eng_head[q*PTR_W +: PTR_W]      = head[q];
      assign eng_tail[q*PTR_W +: PTR_W]      = tail[q];
      assign eng_data_tail[q*PTR_W +: PTR_W] = dtail[q];
    end
  endgenerate

  dmaq_rd_mux #(.NUM_Q(NUM_Q), .PTR_W(PTR_W)) u_rd (
    .hit(hit), .q_idx(q_idx), .sel(sel),
    .base_lo(base_lo), .base_hi(base_hi), .len(len), .head(head), .tail(tail),
    .rdata(rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_valid;
      bus_rdata <= (bus_valid && !bus_write) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/dmaq_ring_csr_chk.sv
module dmaq_ring_csr_chk #(
  parameter int ADDR_W = 16,
  parameter int NUM_Q  = 4,
  parameter int PTR_W  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_ack,
  input logic [31:0]            bus_rdata,
  input logic [NUM_Q-1:0]       eng_consume,
  input logic [NUM_Q-1:0]       eng_pending,
  input logic [NUM_Q-1:0]       eng_kick,
  input logic [NUM_Q*PTR_W-1:0] eng_head,
  input logic [NUM_Q*PTR_W-1:0] eng_tail,
  input logic [NUM_Q*PTR_W-1:0] eng_data_tail
);

  // R9
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> bus_ack);

  // R9
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !bus_ack);

  // R9
  dbell_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr[11:0] == 12'h038) |=> (bus_rdata == 32'h0));

  // R4
  tail_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write) |=> ($stable(eng_tail) && $stable(eng_data_tail)));

  // R5
  head_needs_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_consume == '0) |=> $stable(eng_head));

  // R2
  kick_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write) |=> (eng_kick == '0));

  // R2
  kick_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eng_kick));

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_pend
      // R6
      pending_match_chk: assert property (@(posedge clk) disable iff (rst)
        eng_pending[q] == (eng_tail[q*PTR_W +: PTR_W] != eng_head[q*PTR_W +: PTR_W]));
    end
  endgenerate

endmodule

bind dmaq_ring_csr dmaq_ring_csr_chk #(
  .ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
  .eng_consume(eng_consume), .eng_pending(eng_pending), .eng_kick(eng_kick),
  .eng_head(eng_head), .eng_tail(eng_tail), .eng_data_tail(eng_data_tail)
);

// File: tb/dmaq_ring_csr_tb.sv
module dmaq_ring_csr_tb;

  localparam int ADDR_W = 16;
  localparam int NQ     = 3;
  localparam int PW     = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic              bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [NQ-1:0]     eng_consume = '0;

  logic              ack, ack_rx;
  logic [31:0]       rdata, rdata_rx;
  logic [NQ-1:0]     pend, pend_rx, kick, kick_rx;
  logic [NQ*64-1:0]  base, base_rx;
  logic [NQ*PW-1:0]  len, len_rx, head, head_rx, tail, tail_rx, dtail, dtail_rx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dmaq_ring_csr #(.ADDR_W(ADDR_W), .NUM_Q(NQ), .PTR_W(PW), .IS_TX(1'b1), .HAS_DATA_TAIL(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(ack), .bus_rdata(rdata), .eng_consume(eng_consume),
    .eng_pending(pend), .eng_kick(kick), .eng_base(base), .eng_len(len), .eng_head(head),
    .eng_tail(tail), .eng_data_tail(dtail));

  dmaq_ring_csr #(.ADDR_W(ADDR_W), .NUM_Q(NQ), .PTR_W(PW), .IS_TX(1'b0), .HAS_DATA_TAIL(1'b1)) u_dut_rx (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(ack_rx), .bus_rdata(rdata_rx), .eng_consume(eng_consume),
    .eng_pending(pend_rx), .eng_kick(kick_rx), .eng_base(base_rx), .eng_len(len_rx),
    .eng_head(head_rx), .eng_tail(tail_rx), .eng_data_tail(dtail_rx));

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h2028, 32'hDEADBEEF, 32'h0,        4'd1},  // R1 base low
    '{1'b1, 16'h202C, 32'h12345678, 32'h0,        4'd1},  // R1 base high
    '{1'b1, 16'h2030, 32'd8,        32'h0,        4'd1},  // R1 size 8
    '{1'b0, 16'h2028, 32'h0,        32'hDEADBEEF, 4'd1},  // R1
    '{1'b0, 16'h202C, 32'h0,        32'h12345678, 4'd1},  // R1
    '{1'b0, 16'h2030, 32'h0,        32'd8,        4'd1},  // R1
    '{1'b1, 16'h2038, 32'd5,        32'h0,        4'd2},  // R2 tail 5
    '{1'b0, 16'h203C, 32'h0,        32'd5,        4'd2},  // R2
    '{1'b0, 16'h2038, 32'h0,        32'h0,        4'd9},  // R9 doorbell reads 0
    '{1'b1, 16'h2038, 32'd6,        32'h0,        4'd2},  // R2 wrap to 3
    '{1'b0, 16'h203C, 32'h0,        32'd3,        4'd2},  // R2
    '{1'b1, 16'h203C, 32'd7,        32'h0,        4'd4},  // R4 tail write
    '{1'b0, 16'h203C, 32'h0,        32'd3,        4'd4},  // R4
    '{1'b1, 16'h2038, 32'd8,        32'h0,        4'd3},  // R3 N equals size
    '{1'b0, 16'h203C, 32'h0,        32'd3,        4'd3},  // R3
    '{1'b0, 16'h2034, 32'h0,        32'd0,        4'd4},  // R4 head
    '{1'b0, 16'h4028, 32'h0,        32'h0,        4'd9},  // R9 window past last queue
    '{1'b0, 16'h2040, 32'h0,        32'h0,        4'd9},  // R9 unmapped offset
    '{1'b0, 16'h1030, 32'h0,        32'h0,        4'd1},  // R1 queue 0 untouched
    '{1'b1, 16'h20B0, 32'h1,        32'h0,        4'd7},  // R7 tx tail reset
    '{1'b0, 16'h203C, 32'h0,        32'd0,        4'd7},  // R7
    '{1'b1, 16'h2038, 32'd2,        32'h0,        4'd2},  // R2 tail 2
    '{1'b1, 16'h20E0, 32'd3,        32'h0,        4'd8},  // R8 data tail 3
    '{1'b0, 16'h20E0, 32'h0,        32'h0,        4'd8},  // R8 write-only
    '{1'b0, 16'h103C, 32'h0,        32'h0,        4'd1}   // R1 queue 0 tail
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One bus access (or idle cycle when v=0); results sampled 1 ns after the edge.
  task automatic cyc(input bit v, input bit wr, input logic [15:0] a,
                     input logic [31:0] d, input logic [NQ-1:0] cons);
    @(negedge clk);
    bus_valid   = v;
    bus_write   = wr;
    bus_addr    = a;
    bus_wdata   = d;
    eng_consume = cons;
    @(posedge clk);
    #1;
    bus_valid   = 1'b0;
    bus_write   = 1'b0;
    eng_consume = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 ack", 64'(ack), 64'h0);
    chk("R11 rdata", 64'(rdata), 64'h0);
    chk("R11 tail", 64'(tail), 64'h0);
    chk("R11 pending", 64'(pend), 64'h0);
    chk("R11 base", 64'(base[127:64]), 64'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(1'b1, VECS[i].wr, VECS[i].addr, VECS[i].data, '0);
      chk($sformatf("R9 ack vec %0d", i), 64'(ack), 64'h1);
      if (!VECS[i].wr)
        chk($sformatf("R%0d vec %0d", VECS[i].req, i), 64'(rdata), 64'(VECS[i].exp));
    end

    // Queue 1: size 8, tail 2, head 0, data tail 3. Receive copy: tail 5.
    chk("R1 eng_base", base[127:64], 64'h12345678DEADBEEF);
    chk("R6 pending set", 64'(pend[1]), 64'h1);
    chk("R8 tx data tail", 64'(dtail[15:8]), 64'd3);
    chk("R8 rx data tail gated", 64'(dtail_rx[15:8]), 64'd0);
    chk("R7 rx ignores 0xB0", 64'(tail_rx[15:8]), 64'd5);

    cyc(1'b1, 1'b1, 16'h2064, 32'h1, '0);
    chk("R7 rx reset via 0x64", 64'(tail_rx[15:8]), 64'd0);
    chk("R7 tx ignores 0x64", 64'(tail[15:8]), 64'd2);

    cyc(1'b1, 1'b1, 16'h2038, 32'd1, '0);
    chk("R2 tail 3", 64'(tail[15:8]), 64'd3);
    chk("R2 kick pulse", 64'(kick), 64'b010);
    cyc(1'b0, 1'b0, 16'h0, 32'h0, '0);
    chk("R2 kick one cycle", 64'(kick), 64'b000);

    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 16'h0, 32'h0, 3'b010);
    chk("R5 head 3", 64'(head[15:8]), 64'd3);
    chk("R6 pending clear", 64'(pend[1]), 64'h0);
    cyc(1'b0, 1'b0, 16'h0, 32'h0, 3'b010);
    cyc(1'b1, 1'b0, 16'h2034, 32'h0, '0);
    chk("R5 consume ignored when empty", 64'(rdata), 64'd3);

    cyc(1'b1, 1'b1, 16'h2038, 32'd2, '0);
    cyc(1'b1, 1'b1, 16'h2038, 32'd4, 3'b010);
    chk("R10 tail wraps to 1", 64'(tail[15:8]), 64'd1);
    chk("R10 head 4", 64'(head[15:8]), 64'd4);

    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 16'h0, 32'h0, 3'b010);
    chk("R5 head wraps to 1", 64'(head[15:8]), 64'd1);
    chk("R6 pending after wrap", 64'(pend[1]), 64'h0);

    cyc(1'b1, 1'b1, 16'h3038, 32'd3, '0);
    chk("R3 size zero tail", 64'(tail[23:16]), 64'd0);
    chk("R3 size zero no kick", 64'(kick), 64'b000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule